// File: doc/BRIEF.md
# Two-Cycle Command/Address Sequencer

This block sits on the controller side of a low-power DRAM interface and turns one high-level request into the command stream for a 6-bit, single-data-rate command/address bus with an active-high chip select. It handles four kinds of request: row activate, read, write and mode-register read. Each command on the bus takes two clock cycles. Chip select is high for the first word and low for the second.

Operations that carry an address are split into two commands. A row activate goes out as a first and a second activate command. A read, a write or a mode-register read is always followed by a column-tail command, which carries the low-order column bits. A read or write can also ask for the activate to be placed in front of it, so that a read on a closed row becomes one unbroken run of four commands over eight cycles. Requests whose start column breaks the alignment rule for their kind are refused: the block raises an error pulse and sends nothing on the bus.

Requests use a valid/ready handshake. Ready is also high while the last word of the current sequence is on the bus, so a following request continues without a gap.

Top module: `cas_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, caCs is 0, caBus is 6'b000000 and reqReady is 1.
- R2: Every command occupies two consecutive cycles. In the first, caCs=1 and caBus[2:0] holds the command code. In the second, caCs=0.
- R3: reqOp=0 (activate) sends two commands. The first is {reqBank, 3'b101} then reqRow[14:9]. The second is {reqRow[8:6], 3'b111} then reqRow[5:0].
- R4: reqOp=1 (read, code 3'b010) and reqOp=2 (write, code 3'b100) send {bl, 2'b00, code} then {reqBank, reqCol[9:7]}. This is followed by the column tail {reqCol[6:4], 3'b011} then {reqCol[3:2], 4'b0000}.
- R5: A read or write with reqWithAct=1 sends the activate pair and then the data pair as eight back-to-back cycles, with caCs following 1,0,1,0,1,0,1,0.
- R6: A read whose reqCol[1:0] is not 0 is refused.
- R7: A write whose reqCol[3:0] is not 0 is refused.
- R8: A refused request is still accepted by the handshake. reqErr is 1 for exactly the one cycle after acceptance. In that cycle the bus stays idle and reqReady stays 1.
- R9: reqOp=3 (mode-register read) sends {3'b000, 3'b110} then reqRow[5:0], followed by a column tail of 6'b000011 then 6'b000000, whatever reqCol holds.
- R10: With BL_MODE=2 the bl bit of a read or write equals reqBl. With BL_MODE=0 it is forced to 0, and with BL_MODE=1 it is forced to 1.
- R11: A request is accepted when reqValid and reqReady are both 1. reqReady is also 1 during the final word of a sequence. An accepted legal request puts its first word on the bus in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be taken this cycle |
| reqOp | input | 2 | 0 activate, 1 read, 2 write, 3 mode-register read |
| reqWithAct | input | 1 | Place an activate in front of a read or write |
| reqBank | input | 3 | Bank index |
| reqRow | input | 15 | Row address; bits 5:0 also select the mode register |
| reqCol | input | 10 | Start column |
| reqBl | input | 1 | Per-access burst-length select |
| reqErr | output | 1 | Pulse: previous accepted request was refused |
| caCs | output | 1 | Chip select, high on the first word of a command |
| caBus | output | 6 | Command/address word |

## Verification
Two functions can fall in the same cycle: emitting the final word of one sequence, and accepting the next request, whether legal or refused. The bench provokes this by holding reqValid high across back-to-back requests. One case is an activate followed at once by a read. The other is a read followed by a misaligned write. A behavioural queue model predicts each cycle's word, ready and error flag. It is compared on every clock, so a gap, an overlap or a stray word at the seam fails.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int CA_W   = 6;
  localparam int BANK_W = 3;
  localparam int ROW_W  = 15;
  localparam int COL_W  = 10;
  localparam int STEP_W = 3;

  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_MRR = 2'd3
  } casOp_e;

  localparam logic [2:0] CODE_ACT1 = 3'b101;
  localparam logic [2:0] CODE_ACT2 = 3'b111;
  localparam logic [2:0] CODE_RD   = 3'b010;
  localparam logic [2:0] CODE_WR   = 3'b100;
  localparam logic [2:0] CODE_MRR  = 3'b110;
  localparam logic [2:0] CODE_TAIL = 3'b011;

  localparam logic [CA_W-1:0] CA_IDLE = '0;

  // control -> datapath strobes
  typedef struct packed {
    logic              load;
    logic              reject;
    logic              active;
    logic [STEP_W-1:0] step;
  } ctlStrobe_t;
endpackage

// File: rtl/cas_ctrl.sv
module cas_ctrl
  import cas_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              illegal,
  input  logic [STEP_W-1:0] startStep,
  input  logic [STEP_W-1:0] endStep,
  output logic              reqReady,
  output ctlStrobe_t        strobe
);
  logic              active;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] endQ;
  logic              accept;
  logic              lastWord;

  assign lastWord = active && (step == endQ);
  assign reqReady = !active || lastWord;
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      step   <= '0;
      endQ   <= '0;
    end else if (accept && !illegal) begin
      active <= 1'b1;
      step   <= startStep;
      endQ   <= endStep;
    end else if (lastWord) begin
      active <= 1'b0;
    end else if (active) begin
      step <= step + STEP_W'(1);
    end
  end

  always_comb begin
    strobe.load   = accept && !illegal;
    strobe.reject = accept && illegal;
    strobe.active = active;
    strobe.step   = step;
  end
endmodule

// File: rtl/cas_dpath.sv
module cas_dpath
  import cas_pkg::*;
#(
  parameter int BL_MODE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        reqOp,
  input  logic              reqWithAct,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqBl,
  input  ctlStrobe_t        strobe,
  output logic              illegal,
  output logic [STEP_W-1:0] startStep,
  output logic [STEP_W-1:0] endStep,
  output logic              reqErr,
  output logic              caCs,
  output logic [CA_W-1:0]   caBus
);
  localparam logic [STEP_W-1:0] STEP_DATA = STEP_W'(4);
  localparam logic [STEP_W-1:0] STEP_ACTE = STEP_W'(3);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(7);

  casOp_e opIn;
  casOp_e opQ;
  logic [BANK_W-1:0] bankQ;
  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic              blQ;
  logic              blSel;
  logic              errQ;
  logic [CA_W-1:0]   word;

  assign opIn = casOp_e'(reqOp);

  generate
    if (BL_MODE == 2) begin : g_blDyn
      assign blSel = reqBl;
    end else begin : g_blFix
      assign blSel = (BL_MODE == 1);
    end
  endgenerate

  // alignment and sequence span
  always_comb begin
    illegal   = 1'b0;
    startStep = STEP_DATA;
    endStep   = STEP_LAST;
    unique case (opIn)
      OP_ACT: begin
        startStep = '0;
        endStep   = STEP_ACTE;
      end
      OP_RD: begin
        illegal = (reqCol[1:0] != 2'b00);
        if (reqWithAct) startStep = '0;
      end
      OP_WR: begin
        illegal = (reqCol[3:0] != 4'b0000);
        if (reqWithAct) startStep = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= OP_ACT;
      bankQ <= '0;
      rowQ  <= '0;
      colQ  <= '0;
      blQ   <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      errQ <= strobe.reject;
      if (strobe.load) begin
        opQ   <= opIn;
        bankQ <= reqBank;
        rowQ  <= reqRow;
        colQ  <= reqCol;
        blQ   <= blSel;
      end
    end
  end

  // word formatter: step[2:1] picks the command, step[0] the half
  always_comb begin
    word = CA_IDLE;
    unique case (strobe.step[2:1])
      2'd0: word = strobe.step[0] ? rowQ[14:9] : {bankQ, CODE_ACT1};
      2'd1: word = strobe.step[0] ? rowQ[5:0]  : {rowQ[8:6], CODE_ACT2};
      2'd2: begin
        if (opQ == OP_MRR)
          word = strobe.step[0] ? rowQ[5:0] : {3'b000, CODE_MRR};
        else if (strobe.step[0])
          word = {bankQ, colQ[9:7]};
        else
          word = {blQ, 2'b00, (opQ == OP_WR) ? CODE_WR : CODE_RD};
      end
      default: begin
        if (opQ == OP_MRR)
          word = strobe.step[0] ? 6'b000000 : {3'b000, CODE_TAIL};
        else
          word = strobe.step[0] ? {colQ[3:2], 4'b0000} : {colQ[6:4], CODE_TAIL};
      end
    endcase
  end

  assign caCs   = strobe.active && !strobe.step[0];
  assign caBus  = strobe.active ? word : CA_IDLE;
  assign reqErr = errQ;
endmodule

// File: rtl/cas_seq.sv
module cas_seq
  import cas_pkg::*;
#(
  parameter int BL_MODE = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [1:0]  reqOp,
  input  logic        reqWithAct,
  input  logic [2:0]  reqBank,
  input  logic [14:0] reqRow,
  input  logic [9:0]  reqCol,
  input  logic        reqBl,
  output logic        reqErr,
  output logic        caCs,
  output logic [5:0]  caBus
);
  ctlStrobe_t        strobe;
  logic              illegal;
  logic [STEP_W-1:0] startStep;
  logic [STEP_W-1:0] endStep;

  cas_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .illegal(illegal),
    .startStep(startStep), .endStep(endStep),
    .reqReady(reqReady), .strobe(strobe)
  );

  cas_dpath #(.BL_MODE(BL_MODE)) u_dpath (
    .clk(clk), .rstN(rstN), .reqOp(reqOp), .reqWithAct(reqWithAct),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqBl(reqBl),
    .strobe(strobe), .illegal(illegal), .startStep(startStep),
    .endStep(endStep), .reqErr(reqErr), .caCs(caCs), .caBus(caBus)
  );
endmodule

// File: rtl/cas_seq_chk.sv
module cas_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       reqErr,
  input logic       caCs,
  input logic [5:0] caBus
);
  // R2: a first word is always followed by its second word
  assert_cs_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    caCs |=> !caCs);

  // R1: a cs-low cycle not preceded by a first word is idle
  assert_idle_value_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!caCs && !$past(caCs)) |-> (caBus == 6'b000000));

  // R8: error only after a handshake, and with a quiet bus
  assert_err_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> ($past(reqValid && reqReady) && !caCs && reqReady));

  // R4: a column tail follows a data-moving command
  assert_tail_follows_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    (caCs && caBus[2:0] == 3'b011) |->
      ($past(caCs, 2) && ($past(caBus[2:0], 2) == 3'b010 ||
                          $past(caBus[2:0], 2) == 3'b100 ||
                          $past(caBus[2:0], 2) == 3'b110)));

  // R9: the tail of a mode-register read carries no column bits
  assert_mrr_tail_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (caCs && caBus[2:0] == 3'b011 && $past(caBus[2:0], 2) == 3'b110) |->
      (caBus[5:3] == 3'b000));
endmodule

bind cas_seq cas_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqErr(reqErr), .caCs(caCs), .caBus(caBus)
);

// File: tb/sim_cas_seq.sv
`timescale 1ns/1ps
module sim_cas_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'd0;
  logic        reqWithAct = 1'b0;
  logic [2:0]  reqBank = 3'd0;
  logic [14:0] reqRow = 15'd0;
  logic [9:0]  reqCol = 10'd0;
  logic        reqBl = 1'b0;
  logic        reqErr;
  logic        caCs;
  logic [5:0]  caBus;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  cas_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqWithAct(reqWithAct), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .reqBl(reqBl), .reqErr(reqErr),
    .caCs(caCs), .caBus(caBus)
  );

  // behavioural reference: queue of {cs, word} still to be shown
  logic [6:0] q[$];
  logic       curCs = 1'b0;
  logic [5:0] curCa = 6'd0;
  logic       expErr = 1'b0;
  logic       lastAcc = 1'b0;

  task automatic pushCmd(input logic [5:0] w0, input logic [5:0] w1);
    q.push_back({1'b1, w0});
    q.push_back({1'b0, w1});
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q.delete();
      curCs = 1'b0; curCa = 6'd0; expErr = 1'b0; lastAcc = 1'b0;
    end else begin
      logic acc;
      logic ok;
      acc = reqValid && (q.size() == 0);
      lastAcc = acc;
      expErr = 1'b0;
      ok = 1'b1;
      if (acc) begin
        if (reqOp == 2'd1 && reqCol[1:0] != 0) ok = 1'b0;
        if (reqOp == 2'd2 && reqCol[3:0] != 0) ok = 1'b0;
        expErr = !ok;
        if (ok) begin
          if (reqOp == 2'd0 || (reqOp != 2'd3 && reqWithAct)) begin
            pushCmd({reqBank, 3'b101}, reqRow[14:9]);
            pushCmd({reqRow[8:6], 3'b111}, reqRow[5:0]);
          end
          if (reqOp == 2'd3) begin
            pushCmd(6'b000110, reqRow[5:0]);
            pushCmd(6'b000011, 6'b000000);
          end else if (reqOp != 2'd0) begin
            pushCmd({reqBl, 2'b00, (reqOp == 2'd2) ? 3'b100 : 3'b010},
                    {reqBank, reqCol[9:7]});
            pushCmd({reqCol[6:4], 3'b011}, {reqCol[3:2], 4'b0000});
          end
        end
      end
      if (q.size() > 0) begin
        {curCs, curCa} = q.pop_front();
      end else begin
        curCs = 1'b0; curCa = 6'd0;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      logic expRdy;
      expRdy = (q.size() == 0);
      checks++;
      if (caCs !== curCs || caBus !== curCa || reqReady !== expRdy || reqErr !== expErr) begin
        errors++;
        $display("FAIL %s cycle: actual cs=%b ca=%b rdy=%b err=%b expected cs=%b ca=%b rdy=%b err=%b",
                 tag, caCs, caBus, reqReady, reqErr, curCs, curCa, expRdy, expErr);
      end
    end
  end

  task automatic doReq(input string t, input logic [1:0] op, input logic wa,
                       input logic [2:0] bk, input logic [14:0] row,
                       input logic [9:0] col, input logic bl);
    tag = t;
    reqValid = 1'b1; reqOp = op; reqWithAct = wa; reqBank = bk;
    reqRow = row; reqCol = col; reqBl = bl;
    @(negedge clk);
    while (!lastAcc) @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual still running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (caCs !== 1'b0 || caBus !== 6'd0 || reqReady !== 1'b1 || reqErr !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual cs=%b ca=%b rdy=%b expected 0 000000 1", caCs, caBus, reqReady);
    end
    rstN = 1'b1;
    idle(2);

    doReq("R3", 2'd0, 1'b0, 3'd5, 15'h5A3C, 10'd0, 1'b0); idle(6);
    doReq("R4", 2'd1, 1'b0, 3'd2, 15'd0, 10'h3FC, 1'b0); idle(6);
    doReq("R10", 2'd2, 1'b0, 3'd7, 15'd0, 10'h3F0, 1'b1); idle(6);
    doReq("R9", 2'd3, 1'b0, 3'd1, 15'h002A, 10'h3FF, 1'b1); idle(6);

    // R5: eight contiguous cycles for a read on a closed row
    doReq("R5", 2'd1, 1'b1, 3'd3, 15'h1234, 10'h2A4, 1'b1);
    begin
      logic [7:0] pat;
      for (int i = 0; i < 8; i++) begin
        pat[7-i] = caCs;
        @(negedge clk);
      end
      checks++;
      if (pat !== 8'b10101010 || caCs !== 1'b0 || caBus !== 6'd0) begin
        errors++;
        $display("FAIL R5 cs pattern: actual %b then ca=%b expected 10101010 then 000000", pat, caBus);
      end
    end
    idle(2);

    // R6 / R7: misaligned requests refused
    doReq("R6", 2'd1, 1'b0, 3'd0, 15'd0, 10'h002, 1'b0);
    checks++;
    if (reqErr !== 1'b1 || caCs !== 1'b0) begin
      errors++;
      $display("FAIL R6 refuse: actual err=%b cs=%b expected err=1 cs=0", reqErr, caCs);
    end
    idle(3);
    doReq("R7", 2'd2, 1'b1, 3'd0, 15'd9, 10'h008, 1'b0); idle(3);
    doReq("R7", 2'd2, 1'b0, 3'd4, 15'd0, 10'h010, 1'b0); idle(6);
    doReq("R6", 2'd1, 1'b0, 3'd4, 15'd0, 10'h00C, 1'b0); idle(6);

    // R11 / R8: back-to-back, accept during final word
    doReq("R11", 2'd0, 1'b0, 3'd6, 15'h7FFF, 10'd0, 1'b0);
    doReq("R11", 2'd1, 1'b0, 3'd6, 15'd0, 10'h104, 1'b0);
    doReq("R8", 2'd2, 1'b0, 3'd1, 15'd0, 10'h004, 1'b1);
    checks++;
    if (reqErr !== 1'b1 || reqReady !== 1'b1 || caBus !== 6'd0) begin
      errors++;
      $display("FAIL R8 seam refuse: actual err=%b rdy=%b ca=%b expected 1 1 000000", reqErr, reqReady, caBus);
    end
    doReq("R11", 2'd3, 1'b0, 3'd0, 15'h0011, 10'd0, 1'b0);
    idle(8);
    tag = "R1";
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule